// File: doc/BRIEF.md
# Quadrature Position Counter

This block turns two quadrature phase signals from a rotary or linear encoder into a signed-free position count. Each clock it compares the current phase levels with those of the previous clock. From the edge found it forms a count event and a direction. A 32-bit counter then moves one step up or down. The phase inputs are expected to be already synchronised and filtered.

A 2-bit mode selects between two settings. The first is resolution: every edge of either channel, or only the edges of channel A. The second is the wrap range: the full 32-bit range, or zero up to a programmable maximum. Three sticky event flags record a wrap, a change of direction and a compare match. Each flag is cleared by a one-cycle clear strobe. A single interrupt line is the OR of the flags whose enables are set. Software may load the counter at any time.

Top module: `qpc_core`

## Requirements
- R1: The 32-bit `count` changes by exactly one per valid count event: up when the event's direction is up (`dir` becomes 1), down when it is down (`dir` becomes 0); with no event and no load it holds.
- R2: `mode` encodes 2'b00 = four edges per cycle (both channels) with full-range wrap, 2'b01 = two edges per cycle (channel A only) with full-range wrap, 2'b10 = four edges with bounded wrap, 2'b11 = two edges with bounded wrap; in two-edge modes an edge on channel B alone gives no count.
- R3: Direction rule: at an A edge the event is up when A differs from B after the edge; at a B edge it is up when A equals B after the edge; `dir` takes the direction of each valid event and is 0 after reset.
- R4: With full-range wrap, up from 0xFFFF_FFFF gives 0 and down from 0 gives 0xFFFF_FFFF; either sets `flag_ovf`.
- R5: With bounded wrap, up from `cnt_max` gives 0 and down from 0 gives `cnt_max`; either sets `flag_ovf`.
- R6: While `cmp_en` is 1, a count event that brings `count` to `cnt_cmp`, from either side, sets `flag_cmp`.
- R7: A valid event whose direction differs from the current `dir` sets `flag_dirchg`.
- R8: The flags are sticky; a 1 on `clr_ovf`, `clr_dirchg` or `clr_cmp` clears its flag on the next edge, and a new event in the same cycle wins over the clear.
- R9: `irq` is 1 exactly when some flag is 1 with its enable (`ie_ovf`, `ie_dirchg`, `ie_cmp`) also 1.
- R10: A sample in which both channels change together is ignored: no count, no direction update, no flag.
- R11: While `run` is 0, `count` and `dir` hold and no flag is set; phase history still tracks, so re-enabling makes no spurious count.
- R12: `cnt_wr` loads `cnt_wdata` on the next edge, and a count event in the same cycle is dropped entirely.
- R13: Reset (`rst_n` low) clears `count`, `dir`, the three flags and the phase history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Controller enable |
| mode | input | 2 | Resolution and wrap mode |
| phase_a | input | 1 | Filtered channel A |
| phase_b | input | 1 | Filtered channel B |
| cmp_en | input | 1 | Compare function enable |
| cnt_max | input | 32 | Upper bound for bounded wrap |
| cnt_cmp | input | 32 | Compare value |
| cnt_wr | input | 1 | Counter load strobe |
| cnt_wdata | input | 32 | Counter load value |
| clr_ovf | input | 1 | Clear wrap flag |
| clr_dirchg | input | 1 | Clear direction-change flag |
| clr_cmp | input | 1 | Clear compare flag |
| ie_ovf | input | 1 | Interrupt enable, wrap flag |
| ie_dirchg | input | 1 | Interrupt enable, direction-change flag |
| ie_cmp | input | 1 | Interrupt enable, compare flag |
| count | output | 32 | Position counter |
| dir | output | 1 | Last counting direction, 1 = up |
| flag_ovf | output | 1 | Sticky wrap flag |
| flag_dirchg | output | 1 | Sticky direction-change flag |
| flag_cmp | output | 1 | Sticky compare-match flag |
| irq | output | 1 | Interrupt request |

## Verification
A stale phase history shows up one clock later as a missed, doubled or wrongly signed step on `count`. A wrong stored direction does not move `count`. It appears instead as a spurious or missing `flag_dirchg` on the next valid event. A wrong wrap limit only shows at the boundary, where `count` lands on the wrong value and `flag_ovf` fails to rise in the same clock. All of these are visible one clock after the offending sample. For that reason, the outputs are compared against a reference model on every clock, not only at the end of a scenario.

// File: rtl/qpc_pkg.sv
`timescale 1ns/1ps
package qpc_pkg;
  typedef enum logic [1:0] {
    MODE_X4_FULL  = 2'b00,
    MODE_X2_FULL  = 2'b01,
    MODE_X4_BOUND = 2'b10,
    MODE_X2_BOUND = 2'b11
  } qpc_mode_e;

  localparam int FLAG_N   = 3;
  localparam int FLAG_OVF = 0;
  localparam int FLAG_DIR = 1;
  localparam int FLAG_CMP = 2;

  function automatic logic mode_two_edge(input logic [1:0] m);
    return m[0];
  endfunction

  function automatic logic mode_bounded(input logic [1:0] m);
    return m[1];
  endfunction

  // direction of a single-channel edge, levels taken after the edge
  function automatic logic edge_is_up(input logic a_moved, input logic a, input logic b);
    return a_moved ? (a != b) : (a == b);
  endfunction
endpackage

// File: rtl/qpc_decode.sv
`timescale 1ns/1ps
module qpc_decode
  import qpc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       cnt_wr,
  input  logic [1:0] mode,
  input  logic       phase_a,
  input  logic       phase_b,
  output logic       ev_valid,
  output logic       ev_up,
  output logic       ev_invalid,
  output logic       ev_dirchg,
  output logic       dir
);
  logic a_q, b_q;
  logic a_mv, b_mv, single;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_q <= 1'b0;
      b_q <= 1'b0;
    end else begin
      a_q <= phase_a;
      b_q <= phase_b;
    end
  end

  always_comb begin
    a_mv       = phase_a ^ a_q;
    b_mv       = phase_b ^ b_q;
    ev_invalid = a_mv & b_mv;
    single     = mode_two_edge(mode) ? (a_mv & ~b_mv) : (a_mv ^ b_mv);
    ev_valid   = single & run & ~cnt_wr;
    ev_up      = edge_is_up(a_mv, phase_a, phase_b);
    ev_dirchg  = ev_valid & (ev_up != dir);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        dir <= 1'b0;
    else if (ev_valid) dir <= ev_up;
  end
endmodule

// File: rtl/qpc_counter.sv
`timescale 1ns/1ps
module qpc_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bounded,
  input  logic [CNT_W-1:0] cnt_max,
  input  logic [CNT_W-1:0] cnt_cmp,
  input  logic             cmp_en,
  input  logic             ev_valid,
  input  logic             ev_up,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  output logic [CNT_W-1:0] count,
  output logic             ev_wrap,
  output logic             ev_match
);
  localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] ONE      = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] limit, stepped, nxt;

  function automatic logic [CNT_W-1:0] step_val(
    input logic [CNT_W-1:0] cur, input logic up, input logic [CNT_W-1:0] lim);
    if (up) return (cur == lim) ? '0 : cur + ONE;
    else    return (cur == '0)  ? lim : cur - ONE;
  endfunction

  function automatic logic hits_edge(
    input logic [CNT_W-1:0] cur, input logic up, input logic [CNT_W-1:0] lim);
    return up ? (cur == lim) : (cur == '0);
  endfunction

  always_comb begin
    limit    = bounded ? cnt_max : ALL_ONES;
    stepped  = step_val(count, ev_up, limit);
    ev_wrap  = ev_valid & hits_edge(count, ev_up, limit);
    ev_match = ev_valid & cmp_en & (stepped == cnt_cmp);
    if (cnt_wr)        nxt = cnt_wdata;
    else if (ev_valid) nxt = stepped;
    else               nxt = count;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) count <= '0;
    else        count <= nxt;
  end
endmodule

// File: rtl/qpc_flags.sv
`timescale 1ns/1ps
module qpc_flags #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_ev,
  input  logic [N-1:0] clr,
  input  logic [N-1:0] ie,
  output logic [N-1:0] flags,
  output logic         irq
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)         flags[i] <= 1'b0;
      else if (set_ev[i]) flags[i] <= 1'b1;
      else if (clr[i])    flags[i] <= 1'b0;
    end
  end

  assign irq = |(flags & ie);
endmodule

// File: rtl/qpc_core.sv
`timescale 1ns/1ps
module qpc_core
  import qpc_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [1:0]       mode,
  input  logic             phase_a,
  input  logic             phase_b,
  input  logic             cmp_en,
  input  logic [CNT_W-1:0] cnt_max,
  input  logic [CNT_W-1:0] cnt_cmp,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             clr_ovf,
  input  logic             clr_dirchg,
  input  logic             clr_cmp,
  input  logic             ie_ovf,
  input  logic             ie_dirchg,
  input  logic             ie_cmp,
  output logic [CNT_W-1:0] count,
  output logic             dir,
  output logic             flag_ovf,
  output logic             flag_dirchg,
  output logic             flag_cmp,
  output logic             irq
);
  logic ev_valid, ev_up, ev_invalid, ev_dirchg, ev_wrap, ev_match;
  logic [FLAG_N-1:0] set_v, clr_v, ie_v, flags;

  qpc_decode u_dec (
    .clk, .rst_n, .run, .cnt_wr, .mode, .phase_a, .phase_b,
    .ev_valid, .ev_up, .ev_invalid, .ev_dirchg, .dir
  );

  qpc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk, .rst_n, .bounded(mode_bounded(mode)), .cnt_max, .cnt_cmp, .cmp_en,
    .ev_valid, .ev_up, .cnt_wr, .cnt_wdata, .count, .ev_wrap, .ev_match
  );

  always_comb begin
    set_v = '0; clr_v = '0; ie_v = '0;
    set_v[FLAG_OVF] = ev_wrap;   clr_v[FLAG_OVF] = clr_ovf;    ie_v[FLAG_OVF] = ie_ovf;
    set_v[FLAG_DIR] = ev_dirchg; clr_v[FLAG_DIR] = clr_dirchg; ie_v[FLAG_DIR] = ie_dirchg;
    set_v[FLAG_CMP] = ev_match;  clr_v[FLAG_CMP] = clr_cmp;    ie_v[FLAG_CMP] = ie_cmp;
  end

  qpc_flags #(.N(FLAG_N)) u_flg (
    .clk, .rst_n, .set_ev(set_v), .clr(clr_v), .ie(ie_v), .flags, .irq
  );

  assign flag_ovf    = flags[FLAG_OVF];
  assign flag_dirchg = flags[FLAG_DIR];
  assign flag_cmp    = flags[FLAG_CMP];
endmodule

// File: rtl/qpc_checker.sv
`timescale 1ns/1ps
module qpc_checker #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             cnt_wr,
  input logic [CNT_W-1:0] cnt_wdata,
  input logic [CNT_W-1:0] count,
  input logic             dir,
  input logic             flag_ovf,
  input logic             flag_dirchg,
  input logic             clr_ovf,
  input logic             ev_valid,
  input logic             ev_up,
  input logic             ev_invalid,
  input logic             ev_wrap
);
  assert_step_up_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid && ev_up && !ev_wrap |=> count == $past(count) + 1'b1);

  assert_wrap_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wrap |=> flag_ovf);

  assert_dirchg_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid && (ev_up != dir) |=> flag_dirchg);

  assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flag_ovf && !clr_ovf |=> flag_ovf);

  assert_invalid_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_invalid && !cnt_wr |=> $stable(count) && $stable(dir));

  assert_hold_when_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !run && !cnt_wr |=> $stable(count) && $stable(dir));

  assert_load_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> count == $past(cnt_wdata));
endmodule

bind qpc_core qpc_checker #(.CNT_W(CNT_W)) u_qpc_checker (
  .clk(clk), .rst_n(rst_n), .run(run), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
  .count(count), .dir(dir), .flag_ovf(flag_ovf), .flag_dirchg(flag_dirchg),
  .clr_ovf(clr_ovf), .ev_valid(ev_valid), .ev_up(ev_up),
  .ev_invalid(ev_invalid), .ev_wrap(ev_wrap)
);

// File: tb/test_qpc_core.sv
`timescale 1ns/1ps
module test_qpc_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic        pa = 1'b0, pb = 1'b0;
  logic        cmp_en = 1'b0;
  logic [31:0] cnt_max = '0, cnt_cmp = '0, cnt_wdata = '0;
  logic        cnt_wr = 1'b0;
  logic        clr_ovf = 1'b0, clr_dirchg = 1'b0, clr_cmp = 1'b0;
  logic        ie_ovf = 1'b0, ie_dirchg = 1'b0, ie_cmp = 1'b0;
  logic [31:0] count;
  logic        dir, flag_ovf, flag_dirchg, flag_cmp, irq;

  int errors = 0, checks = 0;
  int ph = 0;
  bit done = 0;

  always #2 clk = ~clk;

  qpc_core i_qpc_core (
    .clk(clk), .rst_n(rst_n), .run(run), .mode(mode), .phase_a(pa), .phase_b(pb),
    .cmp_en(cmp_en), .cnt_max(cnt_max), .cnt_cmp(cnt_cmp), .cnt_wr(cnt_wr),
    .cnt_wdata(cnt_wdata), .clr_ovf(clr_ovf), .clr_dirchg(clr_dirchg),
    .clr_cmp(clr_cmp), .ie_ovf(ie_ovf), .ie_dirchg(ie_dirchg), .ie_cmp(ie_cmp),
    .count(count), .dir(dir), .flag_ovf(flag_ovf), .flag_dirchg(flag_dirchg),
    .flag_cmp(flag_cmp), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model: plain bits and integers
  bit [31:0] m_cnt;
  bit m_dir, m_ovf, m_dch, m_cmp, m_pa, m_pb;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_dir = 0; m_ovf = 0; m_dch = 0; m_cmp = 0; m_pa = 0; m_pb = 0;
    end else begin
      bit ae, be, ev, up, s_ovf, s_dch, s_cmp;
      bit [31:0] lim;
      ae = (pa != m_pa); be = (pb != m_pb);
      ev = 0; s_ovf = 0; s_dch = 0; s_cmp = 0;
      if (run && !cnt_wr && !(ae && be)) ev = mode[0] ? ae : (ae || be);
      if (cnt_wr) m_cnt = cnt_wdata;
      else if (ev) begin
        up  = ae ? (pa != pb) : (pa == pb);
        lim = mode[1] ? cnt_max : 32'hFFFF_FFFF;
        if (up) begin
          if (m_cnt == lim) begin m_cnt = 0; s_ovf = 1; end else m_cnt = m_cnt + 1;
        end else begin
          if (m_cnt == 0) begin m_cnt = lim; s_ovf = 1; end else m_cnt = m_cnt - 1;
        end
        if (up != m_dir) s_dch = 1;
        m_dir = up;
        if (cmp_en && m_cnt == cnt_cmp) s_cmp = 1;
      end
      m_pa = pa; m_pb = pb;
      m_ovf = s_ovf || (m_ovf && !clr_ovf);
      m_dch = s_dch || (m_dch && !clr_dirchg);
      m_cmp = s_cmp || (m_cmp && !clr_cmp);
    end
    #1;
    if (!done) begin
      check("R1 count vs model", count, m_cnt);
      check("R3 dir vs model", {31'b0, dir}, {31'b0, m_dir});
      check("R4 flag_ovf vs model", {31'b0, flag_ovf}, {31'b0, m_ovf});
      check("R7 flag_dirchg vs model", {31'b0, flag_dirchg}, {31'b0, m_dch});
      check("R6 flag_cmp vs model", {31'b0, flag_cmp}, {31'b0, m_cmp});
      check("R9 irq vs model", {31'b0, irq},
            {31'b0, (m_ovf && ie_ovf) || (m_dch && ie_dirchg) || (m_cmp && ie_cmp)});
    end
  end

  task automatic mv(input int d);
    @(negedge clk);
    ph = (ph + d) & 3;
    pa = (ph == 1) || (ph == 2);
    pb = (ph >= 2);
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic clear_all();
    @(negedge clk); clr_ovf = 1; clr_dirchg = 1; clr_cmp = 1;
    @(negedge clk); clr_ovf = 0; clr_dirchg = 0; clr_cmp = 0;
  endtask

  task automatic load(input logic [31:0] v);
    @(negedge clk); cnt_wr = 1; cnt_wdata = v;
    @(negedge clk); cnt_wr = 0;
  endtask

  initial begin
    #(4 * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R13 reset count", count, 32'd0);
    check("R13 reset flags", {29'b0, flag_ovf, flag_dirchg, flag_cmp}, 32'd0);
    rst_n = 1; run = 1; mode = 2'b00;
    settle();
    repeat (8) mv(1); settle();
    check("R1 eight forward x4 steps", count, 32'd8);
    check("R3 forward is up", {31'b0, dir}, 32'd1);
    check("R7 first up event flags change", {31'b0, flag_dirchg}, 32'd1);
    clear_all();
    check("R8 clear strobe", {31'b0, flag_dirchg}, 32'd0);
    mode = 2'b01;
    repeat (8) mv(1); settle();
    check("R2 x2 counts only A edges", count, 32'd12);
    mode = 2'b00;
    repeat (4) mv(-1); settle();
    check("R1 reverse steps down", count, 32'd8);
    check("R3 reverse is down", {31'b0, dir}, 32'd0);
    check("R7 reversal flags change", {31'b0, flag_dirchg}, 32'd1);
    @(negedge clk); ph = (ph + 2) & 3; pa = (ph == 1) || (ph == 2); pb = (ph >= 2);
    settle();
    check("R10 double change ignored", count, 32'd8);
    @(negedge clk); cnt_wr = 1; cnt_wdata = 32'd0;
    ph = (ph + 1) & 3; pa = (ph == 1) || (ph == 2); pb = (ph >= 2);
    @(negedge clk); cnt_wr = 0;
    check("R12 load beats event", count, 32'd0);
    check("R12 dropped event leaves dir", {31'b0, dir}, 32'd0);
    clear_all();
    mv(-1); settle();
    check("R4 underflow wraps", count, 32'hFFFF_FFFF);
    check("R4 underflow flag", {31'b0, flag_ovf}, 32'd1);
    mv(1); settle();
    check("R4 overflow wraps", count, 32'd0);
    mode = 2'b10; cnt_max = 32'd5;
    clear_all();
    load(32'd4);
    mv(1); settle();
    check("R5 reach max", count, 32'd5);
    check("R5 no flag at max", {31'b0, flag_ovf}, 32'd0);
    mv(1); settle();
    check("R5 wrap to zero", count, 32'd0);
    check("R5 wrap flag", {31'b0, flag_ovf}, 32'd1);
    mv(-1); settle();
    check("R5 down wraps to max", count, 32'd5);
    clear_all();
    cmp_en = 1; cnt_cmp = 32'd3;
    mv(-1); settle();
    check("R6 no match at 4", {31'b0, flag_cmp}, 32'd0);
    mv(-1); settle();
    check("R6 match at 3", {31'b0, flag_cmp}, 32'd1);
    check("R9 disabled flag no irq", {31'b0, irq}, 32'd0);
    @(negedge clk); ie_cmp = 1; settle();
    check("R9 enabled flag irq", {31'b0, irq}, 32'd1);
    mv(-1); settle();
    check("R8 flag sticky after leaving", {31'b0, flag_cmp}, 32'd1);
    @(negedge clk); clr_cmp = 1; @(negedge clk); clr_cmp = 0;
    check("R8 cmp cleared", {31'b0, flag_cmp}, 32'd0);
    check("R9 irq drops", {31'b0, irq}, 32'd0);
    @(negedge clk); run = 0;
    repeat (4) mv(1); settle();
    check("R11 held when off", count, 32'd2);
    check("R11 no flag when off", {31'b0, flag_dirchg}, 32'd0);
    @(negedge clk); run = 1; mode = 2'b11;
    repeat (8) mv(1); settle();
    check("R2 x2 bounded", count, 32'd0);
    repeat (4) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule